// File: doc/BRIEF.md
# Superframe Block Error Counters

This block keeps two event counters for a line transceiver's superframe deframer. One counts superframes that report a far-end block error. The other counts near-end block errors. A near-end block error is a superframe whose received CRC fails, or a superframe period that passes while the link is up but superframe alignment has been lost. Each counter moves at most one step per received superframe. The step happens on the cycle that the deframer raises its end-of-superframe strobe.

Software reads both counts at any time. It can load either counter with any value through that counter's own write port. Reset does not touch the count values, so error history survives a reset of the transceiver. Reset does clear a wrap option. With the option clear, a counter holds at its top value. With the option set, a counter wraps back to zero. Every pin is a plain control or status signal. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sfblk_errcnt`

## Requirements
- R1: Each counter is 8 bits wide. A write strobe loads the write data into that counter, and the new value appears on its output after the next rising clock edge.
- R2: Asserting rst_n low leaves both count values unchanged. While rst_n is low, no increment happens even if sf_end pulses.
- R3: The far-end count rises by one after a clock edge where sf_end=1, fe_bit=1, sf_sync=1 and link_up=1. fe_bit=1 means the far-end error indicator is active.
- R4: The far-end count does not change at sf_end when fe_bit=0, or when sf_sync=0, or when link_up=0.
- R5: The near-end count rises by one after a clock edge where sf_end=1 and crc_bad=1, whatever the sync and link states are.
- R6: The near-end count rises by one after a clock edge where sf_end=1, link_up=1 and sf_sync=0, even when crc_bad=0.
- R7: A superframe where crc_bad=1 and, at the same time, link_up=1 with sf_sync=0 raises the near-end count by exactly one.
- R8: Reset clears the wrap option. With the option clear, a counter at 0xFF stays at 0xFF when an increment is due.
- R9: A pulse on wrap_wr loads wrap_val into the wrap option. With the option set, a counter at 0xFF goes to 0x00 when an increment is due.
- R10: If a counter's write strobe and an increment of that counter land on the same cycle, the counter takes the written value.
- R11: While sf_end=0, the fe_bit, crc_bad, sf_sync and link_up inputs have no effect on either count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Clears only the wrap option |
| sf_end | input | 1 | One-cycle strobe at the end of each superframe period |
| fe_bit | input | 1 | Far-end error indicator from the superframe, 1 = error |
| crc_bad | input | 1 | 1 = received CRC differs from the computed CRC |
| sf_sync | input | 1 | 1 = superframe alignment held |
| link_up | input | 1 | 1 = link established |
| wrap_wr | input | 1 | Write strobe for the wrap option |
| wrap_val | input | 1 | Value for the wrap option, 1 = wrap at top |
| fe_wr | input | 1 | Write strobe for the far-end counter |
| fe_wdata | input | 8 | Preset value for the far-end counter |
| ne_wr | input | 1 | Write strobe for the near-end counter |
| ne_wdata | input | 8 | Preset value for the near-end counter |
| fe_count | output | 8 | Far-end error count |
| ne_count | output | 8 | Near-end error count |

## Verification
The bench sweeps all sixteen combinations of indicator, CRC, sync and link. It runs the sweep from several start values, including 0xFE and 0xFF, in both wrap modes. A design that ignored the link or sync gating, or counted the double near-end cause twice, would drift by one from the computed count. A design that wrapped in the default mode, or stuck at the top when wrapping is enabled, would fail at the 0xFF start. The bench also drives reset with strobes active, to catch counters that clear on reset or count while reset is held. It presets a counter on the same cycle as an increment, to catch a design where the increment wins over the write.

// File: rtl/sfblk_pkg.sv
package sfblk_pkg;
  localparam int CNT_W  = 8;
  localparam int NUM_CH = 2;

  typedef enum int {
    CH_FAR  = 0,
    CH_NEAR = 1
  } ch_e;
endpackage

// File: rtl/sfblk_wrap_opt.sv
module sfblk_wrap_opt (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wr,
  input  logic set_val,
  output logic wrap_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wrap_en <= 1'b0;
    else if (set_wr) wrap_en <= set_val;
  end

  // R9
  opt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (wrap_en == $past(set_val)));

  // R8
  opt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wr && $past(rst_n)) |=> $stable(wrap_en));
endmodule

// File: rtl/sfblk_evt_qual.sv
module sfblk_evt_qual (
  input  logic rst_n,
  input  logic sf_end,
  input  logic fe_bit,
  input  logic crc_bad,
  input  logic sf_sync,
  input  logic link_up,
  output logic fe_inc,
  output logic ne_inc
);
  logic live;
  logic aligned;
  logic lost_align;

  always_comb begin
    live       = rst_n & sf_end;
    aligned    = sf_sync & link_up;
    lost_align = link_up & ~sf_sync;
    fe_inc     = live & fe_bit & aligned;
    ne_inc     = live & (crc_bad | lost_align);
  end
endmodule

// File: rtl/sfblk_evt_cnt.sv
module sfblk_evt_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wrap_en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] nxt;
  logic         at_top;

  always_comb begin
    at_top = (cnt == TOP);
    nxt    = cnt;
    if (wr) begin
      nxt = wdata;
    end else if (inc) begin
      if (!at_top)     nxt = cnt + ONE;
      else if (wrap_en) nxt = '0;
    end
  end

  // count survives reset: no reset term on purpose
  always_ff @(posedge clk) cnt <= nxt;

  // R10
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt == $past(wdata)));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr && cnt != TOP) |=> (cnt == $past(cnt) + ONE));

  // R8
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr && !wrap_en && cnt == TOP) |=> (cnt == TOP));

  // R9
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr && wrap_en && cnt == TOP) |=> (cnt == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr) |=> $stable(cnt));
endmodule

// File: rtl/sfblk_errcnt.sv
module sfblk_errcnt
  import sfblk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_end,
  input  logic             fe_bit,
  input  logic             crc_bad,
  input  logic             sf_sync,
  input  logic             link_up,
  input  logic             wrap_wr,
  input  logic             wrap_val,
  input  logic             fe_wr,
  input  logic [CNT_W-1:0] fe_wdata,
  input  logic             ne_wr,
  input  logic [CNT_W-1:0] ne_wdata,
  output logic [CNT_W-1:0] fe_count,
  output logic [CNT_W-1:0] ne_count
);
  logic             wrap_en;
  logic             fe_inc;
  logic             ne_inc;
  logic             inc_v [NUM_CH];
  logic             wr_v  [NUM_CH];
  logic [CNT_W-1:0] wd_v  [NUM_CH];
  logic [CNT_W-1:0] cnt_v [NUM_CH];

  sfblk_wrap_opt u_opt (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_wr  (wrap_wr),
    .set_val (wrap_val),
    .wrap_en (wrap_en)
  );

  sfblk_evt_qual u_qual (
    .rst_n   (rst_n),
    .sf_end  (sf_end),
    .fe_bit  (fe_bit),
    .crc_bad (crc_bad),
    .sf_sync (sf_sync),
    .link_up (link_up),
    .fe_inc  (fe_inc),
    .ne_inc  (ne_inc)
  );

  always_comb begin
    inc_v[CH_FAR]  = fe_inc;
    inc_v[CH_NEAR] = ne_inc;
    wr_v[CH_FAR]   = fe_wr;
    wr_v[CH_NEAR]  = ne_wr;
    wd_v[CH_FAR]   = fe_wdata;
    wd_v[CH_NEAR]  = ne_wdata;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    sfblk_evt_cnt #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc_v[g]),
      .wrap_en (wrap_en),
      .wr      (wr_v[g]),
      .wdata   (wd_v[g]),
      .cnt     (cnt_v[g])
    );
  end

  assign fe_count = cnt_v[CH_FAR];
  assign ne_count = cnt_v[CH_NEAR];

  // R4
  fe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_wr && !(sf_sync && link_up)) |=> $stable(fe_count));

  // R2
  reset_keep_chk: assert property (@(posedge clk)
    (!rst_n && !fe_wr && !ne_wr && $past(1'b1)) |=> ($stable(fe_count) && $stable(ne_count)));
endmodule

// File: tb/sfblk_errcnt_tb_top.sv
module sfblk_errcnt_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sf_end = 0, fe_bit = 0, crc_bad = 0, sf_sync = 0, link_up = 0;
  logic       wrap_wr = 0, wrap_val = 0, fe_wr = 0, ne_wr = 0;
  logic [7:0] fe_wdata = 0, ne_wdata = 0;
  logic [7:0] fe_count, ne_count;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  sfblk_errcnt dut_i (
    .clk(clk), .rst_n(rst_n), .sf_end(sf_end), .fe_bit(fe_bit),
    .crc_bad(crc_bad), .sf_sync(sf_sync), .link_up(link_up),
    .wrap_wr(wrap_wr), .wrap_val(wrap_val), .fe_wr(fe_wr),
    .fe_wdata(fe_wdata), .ne_wr(ne_wr), .ne_wdata(ne_wdata),
    .fe_count(fe_count), .ne_count(ne_count)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic preset(logic [7:0] f, logic [7:0] n);
    fe_wr = 1; ne_wr = 1; fe_wdata = f; ne_wdata = n;
    step();
    fe_wr = 0; ne_wr = 0;
  endtask

  task automatic set_wrap(bit v);
    wrap_wr = 1; wrap_val = v;
    step();
    wrap_wr = 0;
  endtask

  function automatic logic [7:0] nxt(logic [7:0] v, bit inc, bit wrap);
    if (!inc) return v;
    if (v != 8'hFF) return v + 8'd1;
    return wrap ? 8'h00 : 8'hFF;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] starts [5] = '{8'h00, 8'h01, 8'h7E, 8'hFE, 8'hFF};
    repeat (3) @(negedge clk);
    // R1 preset while in reset, R2 reset keeps values, strobes ignored
    preset(8'h33, 8'h44);
    sf_end = 1; fe_bit = 1; crc_bad = 1; sf_sync = 1; link_up = 1;
    repeat (3) step();
    sf_end = 0;
    chk("R2 fe kept in reset", fe_count, 8'h33);
    chk("R2 ne kept in reset", ne_count, 8'h44);
    rst_n = 1;
    step();
    chk("R2 fe after reset", fe_count, 8'h33);
    chk("R1 ne preset", ne_count, 8'h44);

    // R8 default mode after reset saturates
    preset(8'hFF, 8'hFF);
    sf_end = 1; step(); sf_end = 0;
    chk("R8 fe default saturate", fe_count, 8'hFF);
    chk("R8 ne default saturate", ne_count, 8'hFF);

    // R11: inputs ignored without strobe
    for (int p = 0; p < 16; p++) begin
      preset(8'h20, 8'h30);
      {link_up, sf_sync, crc_bad, fe_bit} = 4'(p);
      sf_end = 0;
      step();
      chk("R11 fe no strobe", fe_count, 8'h20);
      chk("R11 ne no strobe", ne_count, 8'h30);
    end

    // main sweep
    for (int w = 0; w < 2; w++) begin
      set_wrap(w[0]);
      for (int s = 0; s < 5; s++) begin
        for (int p = 0; p < 16; p++) begin
          bit f, c, sy, lk, fi, ni;
          string ft, nt;
          preset(starts[s], starts[s]);
          {lk, sy, c, f} = 4'(p);
          {link_up, sf_sync, crc_bad, fe_bit} = 4'(p);
          fi = f & sy & lk;
          ni = c | (lk & ~sy);
          ft = fi ? "R3 fe count" : "R4 fe gated";
          if (c && lk && !sy) nt = "R7 ne single";
          else if (c)         nt = "R5 ne crc";
          else if (lk && !sy) nt = "R6 ne lost sync";
          else                nt = "R5 ne idle";
          if (starts[s] == 8'hFF) begin
            ft = w ? "R9 fe wrap" : "R8 fe saturate";
            nt = w ? "R9 ne wrap" : "R8 ne saturate";
          end
          sf_end = 1; step(); sf_end = 0;
          chk(ft, fe_count, nxt(starts[s], fi, w[0]));
          chk(nt, ne_count, nxt(starts[s], ni, w[0]));
        end
      end
    end

    // R10 write beats increment
    preset(8'h10, 8'h10);
    fe_bit = 1; crc_bad = 1; sf_sync = 1; link_up = 1;
    sf_end = 1; fe_wr = 1; fe_wdata = 8'h55; ne_wr = 1; ne_wdata = 8'hA0;
    step();
    sf_end = 0; fe_wr = 0; ne_wr = 0;
    chk("R10 fe write wins", fe_count, 8'h55);
    chk("R10 ne write wins", ne_count, 8'hA0);

    // R9 then reset clears wrap option -> R8
    set_wrap(1);
    rst_n = 0; step(); rst_n = 1; step();
    preset(8'hFF, 8'hFF);
    sf_end = 1; step(); sf_end = 0;
    chk("R8 fe option cleared by reset", fe_count, 8'hFF);
    chk("R8 ne option cleared by reset", ne_count, 8'hFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule